// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer with a small 16-bit register file. Software programs a timeout in half-second units and enables counting. From then on it must prove it is alive by writing an ordered pair of key words to the service register before the count runs out. If the count expires, the block raises either a held reset request or a held active-low alarm line, depending on a routing bit. A reset request that came from a timeout, and one that came from software, are recorded in a status register that survives the system reset.

The countdown advances on a one-cycle enable pulse at 2 Hz, derived elsewhere from a 32 kHz clock. The block also provides several smaller functions:
- Software can request a one-cycle system reset through an active-low control bit.
- A write-once control bit lets the count freeze while a low-power input is high.
- A boot-time power-down counter is armed after every system reset. Unless software disarms it, it drops the alarm line for exactly one cycle when it expires.

Top module: `wdog_keyed`

## Requirements
- R1: The control register is at byte offset 0x0. Its fields are: timeout field in bits 15:8, route bit in bit 3, enable in bit 2, freeze-permit in bit 0. Bit 4 always reads 1, and bits 7:5 and 1 read 0. After reset it reads 0x0010.
- R2: While enable is 0, ticks have no effect: neither the reset request nor the alarm line changes.
- R3: After enable is set with timeout field F, expiry occurs on tick number F+1. The expiry indication stays asserted until the system reset.
- R4: Writing 0x5555 and then 0xAAAA to the service register at offset 0x2 reloads the count. A further F+1 ticks are then needed for expiry.
- R5: A key sequence that is broken is rejected and does not reload the count. This covers a word other than 0xAAAA written after 0x5555, and 0xAAAA written without a preceding 0x5555.
- R6: Once enable is 1, a control write with bit 2 clear leaves it at 1 until the system reset.
- R7: A control write while enabled reloads the count from the newly written timeout field.
- R8: If freeze-permit is 1, ticks have no effect on the count while the low-power input is high. Freeze-permit is taken from the first control write after reset only, and later writes cannot change it.
- R9: On expiry with route bit 1, the reset request output goes high. On expiry with route bit 0, the alarm line goes low instead and the reset request stays low.
- R10: The status register is at offset 0x4. Bit 1 means a timeout reset and bit 0 means a software reset; the most recent one wins. The status register keeps its value through the system reset and is cleared only by the power-on reset.
- R11: Writing the control register with bit 4 at 0 pulses the software-reset output high for exactly one cycle.
- R12: The misc register is at offset 0x8. Its bit 0 reads 1 after reset, meaning the power-down counter is armed. Writing 0 to bit 0 disarms the counter. Once armed, the counter drives the alarm line low for one cycle on the 32nd tick after reset, unless it was disarmed first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | System reset, active low; clears everything except status |
| por_n | input | 1 | Power-on reset, active low; also clears status |
| tick_2hz | input | 1 | One-cycle count enable at 2 Hz |
| lowpwr | input | 1 | Low-power state indication |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from addr |
| tout_rst | output | 1 | Held timeout reset request |
| sw_rst | output | 1 | One-cycle software reset request |
| wdog_n | output | 1 | Active-low alarm line |

## Verification
Every register write and every tick is taken at a single clock edge, and all of its effects appear right after that edge. This covers a count reload, an expiry, the software-reset pulse and the power-down pulse. The status register is the only exception: it follows the reset outputs one edge later. The bench therefore drives each write or tick for one edge starting at a falling edge, and samples at the next falling edge. Pulse widths are checked by sampling again one falling edge later. Expiry points are checked as the tick before the expected one (still quiet) and the expected tick (asserted).

// File: rtl/wdog_keyed.sv
module wdog_keyed #(
  parameter int PD_TICKS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        por_n,
  input  logic        tick_2hz,
  input  logic        lowpwr,
  input  logic        wr_en,
  input  logic [3:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        tout_rst,
  output logic        sw_rst,
  output logic        wdog_n
);
  localparam int PDW = $clog2(PD_TICKS + 1);
  localparam logic [PDW-1:0] PD_LAST = PDW'(PD_TICKS - 1);
  localparam logic [15:0] KEY_A = 16'h5555;
  localparam logic [15:0] KEY_B = 16'hAAAA;

  logic [7:0]     tmo_q, cnt_q;
  logic           rsel_q, en_q, frz_q, frz_lk_q;
  logic           expired_q, armed_q, sw_q;
  logic           pd_en_q, pd_pulse_q;
  logic [PDW-1:0] pd_cnt_q;
  logic [1:0]     stat_q;

  wire wr_ctl  = wr_en && (addr == 4'h0);
  wire wr_svc  = wr_en && (addr == 4'h2);
  wire wr_misc = wr_en && (addr == 4'h8);
  wire key_ok  = wr_svc && armed_q && (wdata == KEY_B);
  wire run     = en_q && !expired_q && !(frz_q && lowpwr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q    <= '0;
      rsel_q   <= 1'b0;
      en_q     <= 1'b0;
      frz_q    <= 1'b0;
      frz_lk_q <= 1'b0;
    end else if (wr_ctl) begin
      tmo_q  <= wdata[15:8];
      rsel_q <= wdata[3];
      if (wdata[2]) en_q <= 1'b1;
      if (!frz_lk_q) begin
        frz_q    <= wdata[0];
        frz_lk_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      expired_q <= 1'b0;
    end else if (wr_ctl && (en_q || wdata[2])) begin
      cnt_q <= wdata[15:8];
    end else if (key_ok) begin
      cnt_q <= tmo_q;
    end else if (tick_2hz && run) begin
      if (cnt_q == 8'd0) expired_q <= 1'b1;
      else               cnt_q     <= cnt_q - 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed_q <= 1'b0;
    else if (wr_svc) armed_q <= (wdata == KEY_A);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_en_q    <= 1'b1;
      pd_cnt_q   <= '0;
      pd_pulse_q <= 1'b0;
    end else begin
      pd_pulse_q <= 1'b0;
      if (wr_misc && !wdata[0]) begin
        pd_en_q <= 1'b0;
      end else if (tick_2hz && pd_en_q) begin
        if (pd_cnt_q == PD_LAST) begin
          pd_pulse_q <= 1'b1;
          pd_en_q    <= 1'b0;
        end else begin
          pd_cnt_q <= pd_cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_q <= 1'b0;
    else        sw_q <= wr_ctl && !wdata[4];
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        stat_q <= 2'b00;
    else if (sw_q)     stat_q <= 2'b01;
    else if (tout_rst) stat_q <= 2'b10;
  end

  assign tout_rst = expired_q && rsel_q;
  assign sw_rst   = sw_q;
  assign wdog_n   = !(pd_pulse_q || (expired_q && !rsel_q));

  always_comb begin
    case (addr)
      4'h0:    rdata = {tmo_q, 3'b000, 1'b1, rsel_q, en_q, 1'b0, frz_q};
      4'h4:    rdata = {14'd0, stat_q};
      4'h8:    rdata = {15'd0, pd_en_q};
      default: rdata = 16'h0000;
    endcase
  end
endmodule

module wdog_keyed_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       por_n,
  input logic       lowpwr,
  input logic       wr_en,
  input logic       en_q,
  input logic       frz_q,
  input logic       expired_q,
  input logic [7:0] cnt_q,
  input logic       sw_rst,
  input logic       tout_rst,
  input logic       pd_pulse_q,
  input logic [1:0] stat_q
);
  p_enable_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);
  p_expiry_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    expired_q |=> expired_q);
  p_freeze_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_q && lowpwr && !wr_en) |=> $stable(cnt_q));
  p_sw_pulse_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> !sw_rst);
  p_pd_pulse_one_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pd_pulse_q |=> !pd_pulse_q);
  p_status_single_r10: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0(stat_q));
  p_route_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tout_rst |-> expired_q);
endmodule

bind wdog_keyed wdog_keyed_chk u_chk (
  .clk(clk), .rst_n(rst_n), .por_n(por_n), .lowpwr(lowpwr), .wr_en(wr_en),
  .en_q(en_q), .frz_q(frz_q), .expired_q(expired_q), .cnt_q(cnt_q),
  .sw_rst(sw_rst), .tout_rst(tout_rst), .pd_pulse_q(pd_pulse_q), .stat_q(stat_q)
);

// File: tb/wdog_keyed_tb.sv
module wdog_keyed_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0, por_n = 1'b0;
  logic        tick_2hz = 1'b0, lowpwr = 1'b0, wr_en = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        tout_rst, sw_rst, wdog_n;
  int total = 0, bad = 0;

  wdog_keyed u_dut (.clk(clk), .rst_n(rst_n), .por_n(por_n), .tick_2hz(tick_2hz),
    .lowpwr(lowpwr), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .tout_rst(tout_rst), .sw_rst(sw_rst), .wdog_n(wdog_n));

  always #4 clk = ~clk;

  function automatic int ticks_to_expire(input int f);
    return f + 1;
  endfunction

  function automatic logic [15:0] ctrl_word(input logic [7:0] f, input logic rs,
                                            input logic en, input logic fz);
    return {f, 3'b000, 1'b1, rs, en, 1'b0, fz};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_2hz = 1'b1;
      @(negedge clk); tick_2hz = 1'b0;
    end
  endtask

  task automatic sys_reset(input logic por);
    @(negedge clk); rst_n = 1'b0; if (por) por_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog timer expired");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd1234));
    sys_reset(1'b1);
    // reset state
    rd(4'h0, v); chk("R1 reset ctrl", v, 16'h0010);
    rd(4'h8, v); chk("R12 reset misc", v, 16'h0001);
    rd(4'h4, v); chk("R10 reset status", v, 16'h0000);
    chk("R9 reset outputs", {13'd0, tout_rst, sw_rst, wdog_n}, 16'h0001);
    wr(4'h8, 16'h0000);
    rd(4'h8, v); chk("R12 disarmed", v, 16'h0000);

    // R1 field placement, R2 no counting while disabled
    wr(4'h0, 16'h3A18);
    rd(4'h0, v); chk("R1 ctrl readback", v, ctrl_word(8'h3A, 1'b1, 1'b0, 1'b0));
    tick(80);
    chk("R2 disabled no expiry", {14'd0, tout_rst, wdog_n}, 16'h0001);

    // R3/R4 random timeouts with refresh
    for (int i = 0; i < 8; i++) begin
      int f, n;
      f = $urandom_range(1, 20);
      n = $urandom_range(0, f);
      sys_reset(1'b0); wr(4'h8, 16'h0000);
      wr(4'h0, {f[7:0], 8'h1C});
      tick(n);
      wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
      chk("R4 after refresh quiet", {15'd0, tout_rst}, 16'h0000);
      tick(ticks_to_expire(f) - 1);
      chk("R4 one tick before expiry", {15'd0, tout_rst}, 16'h0000);
      tick(1);
      chk("R3 expiry on tick F+1", {15'd0, tout_rst}, 16'h0001);
      tick(3);
      chk("R3 expiry held", {15'd0, tout_rst}, 16'h0001);
    end

    // R5 broken sequences do not reload
    sys_reset(1'b0); wr(4'h8, 16'h0000);
    wr(4'h0, 16'h051C);
    tick(3);
    wr(4'h2, 16'h5555); wr(4'h2, 16'h1234); wr(4'h2, 16'hAAAA);
    tick(2);
    chk("R5 interrupted key no reload, not yet", {15'd0, tout_rst}, 16'h0000);
    tick(1);
    chk("R5 interrupted key no reload, expired", {15'd0, tout_rst}, 16'h0001);
    sys_reset(1'b0); wr(4'h8, 16'h0000);
    wr(4'h0, 16'h041C);
    tick(3);
    wr(4'h2, 16'hAAAA);
    tick(2);
    chk("R5 lone second key no reload", {15'd0, tout_rst}, 16'h0001);

    // R6 sticky enable, R7 field rewrite reloads
    sys_reset(1'b0); wr(4'h8, 16'h0000);
    wr(4'h0, 16'h051C);
    tick(4);
    wr(4'h0, 16'h0318);
    rd(4'h0, v); chk("R6 enable stays set", v, ctrl_word(8'h03, 1'b1, 1'b1, 1'b0));
    tick(3);
    chk("R7 reloaded not expired", {15'd0, tout_rst}, 16'h0000);
    tick(1);
    chk("R7 expiry after new field", {15'd0, tout_rst}, 16'h0001);

    // R8 freeze during low power
    sys_reset(1'b0); wr(4'h8, 16'h0000);
    wr(4'h0, 16'h041D);
    lowpwr = 1'b1; tick(20); lowpwr = 1'b0;
    chk("R8 frozen in low power", {15'd0, tout_rst}, 16'h0000);
    tick(4);
    chk("R8 resume not yet", {15'd0, tout_rst}, 16'h0000);
    tick(1);
    chk("R8 resume expiry", {15'd0, tout_rst}, 16'h0001);
    sys_reset(1'b0); wr(4'h8, 16'h0000);
    wr(4'h0, 16'h0418);
    wr(4'h0, 16'h041D);
    rd(4'h0, v); chk("R8 write-once freeze bit", v, ctrl_word(8'h04, 1'b1, 1'b1, 1'b0));
    lowpwr = 1'b1; tick(5); lowpwr = 1'b0;
    chk("R8 no freeze when not permitted", {15'd0, tout_rst}, 16'h0001);

    // R9 alarm routing
    sys_reset(1'b1); wr(4'h8, 16'h0000);
    wr(4'h0, 16'h0214);
    tick(3);
    chk("R9 alarm line route", {14'd0, tout_rst, wdog_n}, 16'h0000);
    rd(4'h4, v); chk("R10 no status on alarm route", v, 16'h0000);

    // R10 status retention
    sys_reset(1'b0); wr(4'h8, 16'h0000);
    wr(4'h0, 16'h011C);
    tick(2);
    chk("R9 reset route", {14'd0, tout_rst, wdog_n}, 16'h0003);
    sys_reset(1'b0);
    rd(4'h4, v); chk("R10 timeout cause kept", v, 16'h0002);
    chk("R10 request cleared by reset", {15'd0, tout_rst}, 16'h0000);

    // R11 software reset pulse
    wr(4'h8, 16'h0000);
    wr(4'h0, 16'h0000);
    chk("R11 pulse high", {15'd0, sw_rst}, 16'h0001);
    @(negedge clk);
    chk("R11 pulse one cycle", {15'd0, sw_rst}, 16'h0000);
    rd(4'h0, v); chk("R11 bit reads one", v & 16'h0010, 16'h0010);
    rd(4'h4, v); chk("R10 software cause", v, 16'h0001);
    sys_reset(1'b1);
    rd(4'h4, v); chk("R10 power-on clears", v, 16'h0000);

    // R12 power-down counter
    tick(31);
    chk("R12 before 32nd tick", {15'd0, wdog_n}, 16'h0001);
    tick(1);
    chk("R12 pulse low", {15'd0, wdog_n}, 16'h0000);
    @(negedge clk);
    chk("R12 pulse one cycle", {15'd0, wdog_n}, 16'h0001);
    sys_reset(1'b0);
    tick(10); wr(4'h8, 16'h0000);
    begin
      logic seen_low;
      seen_low = 1'b0;
      for (int i = 0; i < 40; i++) begin
        tick(1);
        if (!wdog_n) seen_low = 1'b1;
      end
      chk("R12 disarmed no pulse", {15'd0, seen_low}, 16'h0000);
    end
    finish_run();
  end
endmodule